// File: doc/BRIEF.md
# Control-Transfer Target Alignment Checker

This block resolves the target of every jump and branch in the execute stage of a 64-bit integer core. It decides whether the instruction redirects the program counter or raises an instruction-address-misaligned exception. It takes the instruction class, the branch outcome, the source register value, the immediate, the instruction address, the destination register index and a run-time flag that enables 16-bit instructions. Its outputs are the redirect request and target, the link-register write, and the trap request with its cause, exception PC and faulting address.

Each instruction presented with `valid_i` is resolved in one pass of combinational logic. The results are captured in a single output register stage, so they appear on the ports one clock edge later. The trap fields are the values a downstream trap unit would latch. Decode, the register file and CSR storage are outside this block.

Top module: `ctchk_top`

## Requirements
- R1: The target is computed by instruction class. JAL (op_i=1) and a conditional branch (op_i=3) use pc_i+imm_i. JALR (op_i=2) uses rs1_i+imm_i with bit 0 forced to zero. All sums wrap at 64 bits. When redirect_valid_o is high, redirect_pc_o carries this target; otherwise redirect_pc_o is zero.
- R2: A JALR whose sum differs from an aligned address only in bit 0 never traps.
- R3: With rvc_en_i=0, a transfer whose target has bit 1 or bit 0 set traps. With rvc_en_i=1, only a set bit 0 traps, and targets aligned to 2 bytes are legal.
- R4: The check applies alike to JAL, JALR and taken branches (taken_i=1). A not-taken branch never redirects and never traps. Neither does op_i=0 or valid_i=0.
- R5: A trapping transfer holds redirect_valid_o low and does not write the link register (rd_we_o low).
- R6: A JAL or JALR that does not trap writes pc_i+4 to rd_i (rd_we_o high, rd_addr_o=rd_i, rd_wdata_o=pc_i+4), except when rd_i is 0. Branches never write. When rd_we_o is low, rd_addr_o and rd_wdata_o are zero.
- R7: On a trap, trap_cause_o is 0 (misaligned fetch, interrupt bit clear), trap_epc_o is the pc_i of the jump or branch itself, and trap_tval_o is the misaligned target. With no trap, all three are zero.
- R8: All results appear one clock edge after the instruction is presented. rvc_en_i is sampled together with that instruction, so legality can change between back-to-back instructions.
- R9: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 2 | 0 none, 1 JAL, 2 JALR, 3 conditional branch |
| taken_i | input | 1 | Branch condition outcome |
| rs1_i | input | 64 | JALR base register value |
| imm_i | input | 64 | Sign-extended immediate |
| pc_i | input | 64 | Address of the instruction |
| rd_i | input | 5 | Destination register index |
| rvc_en_i | input | 1 | 16-bit instructions enabled |
| redirect_valid_o | output | 1 | PC redirect request |
| redirect_pc_o | output | 64 | Redirect target |
| rd_we_o | output | 1 | Link register write enable |
| rd_addr_o | output | 5 | Link register index |
| rd_wdata_o | output | 64 | Return address |
| trap_o | output | 1 | Misaligned-fetch trap request |
| trap_cause_o | output | 64 | Trap cause |
| trap_epc_o | output | 64 | Address of the faulting instruction |
| trap_tval_o | output | 64 | Faulting target address |

## Verification
If the alignment mask or the target mux were chosen wrongly, the first affected instruction would show it on the very next edge. Either trap_o and redirect_valid_o would both disagree with the expected outcome, or a leaked link write would appear beside a trap. Because nothing is carried from one instruction to the next beyond the output register, an error never persists or hides. It shows at the ports one cycle after the input that exposes it. That makes back-to-back instructions with a toggling rvc_en_i the sharpest probe of stale sampling.

// File: rtl/ctchk_pkg.sv
package ctchk_pkg;
  typedef enum logic [1:0] {
    CT_NONE = 2'd0,
    CT_JAL  = 2'd1,
    CT_JALR = 2'd2,
    CT_BR   = 2'd3
  } ct_op_e;

  localparam int unsigned CAUSE_FETCH_MISALIGNED = 0;
  localparam int unsigned LINK_BYTES = 4;
  localparam logic [1:0]  MASK_STRICT = 2'b11;
  localparam logic [1:0]  MASK_COMPR  = 2'b01;
endpackage

// File: rtl/ctchk_target.sv
module ctchk_target
  import ctchk_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  ct_op_e          op_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] sum;

  always_comb begin
    base = (op_i == CT_JALR) ? rs1_i : pc_i;
    sum  = base + imm_i;
    target_o = sum;
    // indirect jump discards bit 0 before any alignment test
    if (op_i == CT_JALR) target_o[0] = 1'b0;
  end

  assign link_o = pc_i + XLEN'(LINK_BYTES);
endmodule

// File: rtl/ctchk_align.sv
module ctchk_align
  import ctchk_pkg::*;
#(
  parameter int unsigned LOW_BITS = 2
) (
  input  logic                valid_i,
  input  ct_op_e              op_i,
  input  logic                taken_i,
  input  logic                rvc_en_i,
  input  logic [LOW_BITS-1:0] tgt_low_i,
  output logic                xfer_o,
  output logic                fault_o
);
  logic [LOW_BITS-1:0] mask;
  logic [LOW_BITS-1:0] hit;

  assign mask = rvc_en_i ? LOW_BITS'(MASK_COMPR) : LOW_BITS'(MASK_STRICT);

  for (genvar b = 0; b < LOW_BITS; b++) begin : g_bit
    assign hit[b] = tgt_low_i[b] & mask[b];
  end

  always_comb begin
    unique case (op_i)
      CT_JAL, CT_JALR: xfer_o = valid_i;
      CT_BR:           xfer_o = valid_i & taken_i;
      default:         xfer_o = 1'b0;
    endcase
  end

  assign fault_o = xfer_o & (|hit);
endmodule

// File: rtl/ctchk_outreg.sv
module ctchk_outreg #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             redir_d,
  input  logic [XLEN-1:0]  redir_pc_d,
  input  logic             we_d,
  input  logic [REG_W-1:0] waddr_d,
  input  logic [XLEN-1:0]  wdata_d,
  input  logic             trap_d,
  input  logic [XLEN-1:0]  cause_d,
  input  logic [XLEN-1:0]  epc_d,
  input  logic [XLEN-1:0]  tval_d,
  output logic             redir_q,
  output logic [XLEN-1:0]  redir_pc_q,
  output logic             we_q,
  output logic [REG_W-1:0] waddr_q,
  output logic [XLEN-1:0]  wdata_q,
  output logic             trap_q,
  output logic [XLEN-1:0]  cause_q,
  output logic [XLEN-1:0]  epc_q,
  output logic [XLEN-1:0]  tval_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
      we_q       <= 1'b0;
      waddr_q    <= '0;
      wdata_q    <= '0;
      trap_q     <= 1'b0;
      cause_q    <= '0;
      epc_q      <= '0;
      tval_q     <= '0;
    end else begin
      redir_q    <= redir_d;
      redir_pc_q <= redir_pc_d;
      we_q       <= we_d;
      waddr_q    <= waddr_d;
      wdata_q    <= wdata_d;
      trap_q     <= trap_d;
      cause_q    <= cause_d;
      epc_q      <= epc_d;
      tval_q     <= tval_d;
    end
  end
endmodule

// File: rtl/ctchk_top.sv
module ctchk_top
  import ctchk_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic             taken_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [XLEN-1:0]  imm_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic             rvc_en_i,
  output logic             redirect_valid_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic             rd_we_o,
  output logic [REG_W-1:0] rd_addr_o,
  output logic [XLEN-1:0]  rd_wdata_o,
  output logic             trap_o,
  output logic [XLEN-1:0]  trap_cause_o,
  output logic [XLEN-1:0]  trap_epc_o,
  output logic [XLEN-1:0]  trap_tval_o
);
  localparam int unsigned LOW_BITS = 2;

  ct_op_e          op;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] link;
  logic            xfer;
  logic            fault;
  logic            is_jump;
  logic            redir_d;
  logic            we_d;

  assign op = ct_op_e'(op_i);

  ctchk_target #(.XLEN(XLEN)) u_target (
    .op_i    (op),
    .rs1_i   (rs1_i),
    .imm_i   (imm_i),
    .pc_i    (pc_i),
    .target_o(target),
    .link_o  (link)
  );

  ctchk_align #(.LOW_BITS(LOW_BITS)) u_align (
    .valid_i  (valid_i),
    .op_i     (op),
    .taken_i  (taken_i),
    .rvc_en_i (rvc_en_i),
    .tgt_low_i(target[LOW_BITS-1:0]),
    .xfer_o   (xfer),
    .fault_o  (fault)
  );

  assign is_jump = valid_i & ((op == CT_JAL) | (op == CT_JALR));
  assign redir_d = xfer & ~fault;
  // faulting jumps must not link; x0 writes are dropped
  assign we_d    = is_jump & ~fault & (rd_i != '0);

  ctchk_outreg #(.XLEN(XLEN), .REG_W(REG_W)) u_outreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .redir_d   (redir_d),
    .redir_pc_d(redir_d ? target : '0),
    .we_d      (we_d),
    .waddr_d   (we_d ? rd_i : '0),
    .wdata_d   (we_d ? link : '0),
    .trap_d    (fault),
    .cause_d   (XLEN'(CAUSE_FETCH_MISALIGNED)),
    .epc_d     (fault ? pc_i : '0),
    .tval_d    (fault ? target : '0),
    .redir_q   (redirect_valid_o),
    .redir_pc_q(redirect_pc_o),
    .we_q      (rd_we_o),
    .waddr_q   (rd_addr_o),
    .wdata_q   (rd_wdata_o),
    .trap_q    (trap_o),
    .cause_q   (trap_cause_o),
    .epc_q     (trap_epc_o),
    .tval_q    (trap_tval_o)
  );
endmodule

// File: rtl/ctchk_sva.sv
module ctchk_sva #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       op_i,
  input logic             taken_i,
  input logic [XLEN-1:0]  pc_i,
  input logic             rvc_en_i,
  input logic             redirect_valid_o,
  input logic [XLEN-1:0]  redirect_pc_o,
  input logic             rd_we_o,
  input logic [REG_W-1:0] rd_addr_o,
  input logic             trap_o,
  input logic [XLEN-1:0]  trap_cause_o,
  input logic [XLEN-1:0]  trap_epc_o,
  input logic [XLEN-1:0]  trap_tval_o
);
  p_trap_blocks_redirect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_o && redirect_valid_o));

  p_trap_blocks_link_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !rd_we_o);

  p_no_x0_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_addr_o != '0));

  p_not_taken_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3 && !taken_i) |=> (!trap_o && !redirect_valid_o && !rd_we_o));

  p_target_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> !redirect_pc_o[0]);

  p_strict_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rvc_en_i) |=> (!redirect_valid_o || !redirect_pc_o[1]));

  p_trap_fields_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_cause_o == '0 && trap_epc_o == $past(pc_i) && trap_tval_o[1:0] != 2'b00));
endmodule

bind ctchk_top ctchk_sva #(.XLEN(XLEN), .REG_W(REG_W)) u_sva (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .valid_i         (valid_i),
  .op_i            (op_i),
  .taken_i         (taken_i),
  .pc_i            (pc_i),
  .rvc_en_i        (rvc_en_i),
  .redirect_valid_o(redirect_valid_o),
  .redirect_pc_o   (redirect_pc_o),
  .rd_we_o         (rd_we_o),
  .rd_addr_o       (rd_addr_o),
  .trap_o          (trap_o),
  .trap_cause_o    (trap_cause_o),
  .trap_epc_o      (trap_epc_o),
  .trap_tval_o     (trap_tval_o)
);

// File: tb/ctchk_top_tb_top.sv
module ctchk_top_tb_top;
  localparam int XLEN = 64;

  typedef struct {
    string       tag;
    logic        redir;
    logic [63:0] redir_pc;
    logic        we;
    logic [4:0]  waddr;
    logic [63:0] wdata;
    logic        trap;
    logic [63:0] epc;
    logic [63:0] tval;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        taken = 1'b0;
  logic [63:0] rs1 = '0, imm = '0, pc = '0;
  logic [4:0]  rd = '0;
  logic        rvc = 1'b0;

  logic        redir_o, we_o, trap_o;
  logic [63:0] redir_pc_o, wdata_o, cause_o, epc_o, tval_o;
  logic [4:0]  waddr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  ctchk_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .taken_i(taken),
    .rs1_i(rs1), .imm_i(imm), .pc_i(pc), .rd_i(rd), .rvc_en_i(rvc),
    .redirect_valid_o(redir_o), .redirect_pc_o(redir_pc_o),
    .rd_we_o(we_o), .rd_addr_o(waddr_o), .rd_wdata_o(wdata_o),
    .trap_o(trap_o), .trap_cause_o(cause_o), .trap_epc_o(epc_o), .trap_tval_o(tval_o)
  );

  task automatic chk(input string tag, input string f, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, f, act, exp);
    end
  endtask

  // reference model built from the requirements
  function automatic exp_t model(input string tag, input logic v, input logic [1:0] o,
                                 input logic t, input logic [63:0] r, input logic [63:0] i,
                                 input logic [63:0] p, input logic [4:0] d, input logic c);
    exp_t e;
    logic [63:0] tgt;
    logic xfer, bad;
    e.tag = tag;
    tgt = (o == 2'd2) ? ((r + i) & ~64'd1) : (p + i);
    xfer = v && (o == 2'd1 || o == 2'd2 || (o == 2'd3 && t));
    bad = c ? tgt[0] : (tgt[1] || tgt[0]);
    e.trap = xfer && bad;
    e.redir = xfer && !bad;
    e.redir_pc = e.redir ? tgt : 64'd0;
    e.we = v && (o == 2'd1 || o == 2'd2) && !bad && d != 5'd0;
    e.waddr = e.we ? d : 5'd0;
    e.wdata = e.we ? p + 64'd4 : 64'd0;
    e.epc = e.trap ? p : 64'd0;
    e.tval = e.trap ? tgt : 64'd0;
    return e;
  endfunction

  task automatic drive(input string tag, input logic v, input logic [1:0] o, input logic t,
                       input logic [63:0] r, input logic [63:0] i, input logic [63:0] p,
                       input logic [4:0] d, input logic c);
    @(negedge clk);
    valid = v; op = o; taken = t; rs1 = r; imm = i; pc = p; rd = d; rvc = c;
    sb.push_back(model(tag, v, o, t, r, i, p, d, c));
  endtask

  always @(posedge clk) begin
    if (mon_en && sb.size() > 0) begin
      exp_t e;
      #1;
      e = sb.pop_front();
      chk(e.tag, "redirect_valid", 64'(redir_o), 64'(e.redir));
      chk(e.tag, "redirect_pc", redir_pc_o, e.redir_pc);
      chk(e.tag, "rd_we", 64'(we_o), 64'(e.we));
      chk(e.tag, "rd_addr", 64'(waddr_o), 64'(e.waddr));
      chk(e.tag, "rd_wdata", wdata_o, e.wdata);
      chk(e.tag, "trap", 64'(trap_o), 64'(e.trap));
      chk(e.tag, "trap_cause", cause_o, 64'd0);
      chk(e.tag, "trap_epc", epc_o, e.epc);
      chk(e.tag, "trap_tval", tval_o, e.tval);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #3;
    // R9: outputs held at zero under reset
    chk("R9", "any_valid", 64'({redir_o, we_o, trap_o}), 64'd0);
    chk("R9", "data", redir_pc_o | wdata_o | epc_o | tval_o | cause_o | 64'(waddr_o), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R1 JAL / JALR / branch targets, aligned
    drive("R1_jal",    1, 2'd1, 0, 64'h0,    64'h20, 64'h1000, 5'd1, 0);
    drive("R1_jalr",   1, 2'd2, 0, 64'h4000, 64'h10, 64'h1004, 5'd5, 0);
    drive("R1_br",     1, 2'd3, 1, 64'h0,    -64'sd8, 64'h1008, 5'd7, 0);
    drive("R1_wrap",   1, 2'd1, 0, 64'h0,    64'h10, 64'hFFFF_FFFF_FFFF_FFF0, 5'd3, 0);
    // R2 JALR low bit discarded
    drive("R2_b0",     1, 2'd2, 0, 64'h2000, 64'h1, 64'h1100, 5'd1, 0);
    drive("R2_b1_strict", 1, 2'd2, 0, 64'h2001, 64'h2, 64'h1104, 5'd1, 0);
    drive("R2_b1_compr",  1, 2'd2, 0, 64'h2001, 64'h2, 64'h1108, 5'd1, 1);
    // R3 compressed flag changes legality
    drive("R3_jal_strict", 1, 2'd1, 0, 64'h0, 64'h6, 64'h100, 5'd1, 0);
    drive("R3_jal_compr",  1, 2'd1, 0, 64'h0, 64'h6, 64'h100, 5'd1, 1);
    drive("R3_odd_compr",  1, 2'd1, 0, 64'h0, 64'h7, 64'h200, 5'd2, 1);
    // R4 taken vs not-taken, and idle
    drive("R4_br_taken", 1, 2'd3, 1, 64'h0, 64'hA, 64'h300, 5'd4, 0);
    drive("R4_br_not",   1, 2'd3, 0, 64'h0, 64'hA, 64'h300, 5'd4, 0);
    drive("R4_none",     1, 2'd0, 1, 64'h0, 64'h2, 64'h300, 5'd4, 0);
    drive("R4_invalid",  0, 2'd1, 1, 64'h0, 64'h2, 64'h300, 5'd4, 0);
    // R5 trap suppresses link and redirect
    drive("R5_jalr_trap", 1, 2'd2, 0, 64'h5002, 64'h0, 64'h400, 5'd31, 0);
    // R6 link rules
    drive("R6_x0",     1, 2'd1, 0, 64'h0, 64'h40, 64'h500, 5'd0, 0);
    drive("R6_br_rd",  1, 2'd3, 1, 64'h0, 64'h40, 64'h504, 5'd9, 1);
    // R7 trap fields with high address bits
    drive("R7_fields", 1, 2'd3, 1, 64'h0, 64'h2, 64'h8000_0000_0000_0010, 5'd0, 0);
    // R8 back-to-back with rvc toggling each instruction
    for (int k = 0; k < 16; k++) begin
      drive("R8_toggle", 1, 2'(1 + (k % 3)), k[1], 64'h6000 + 64'(k), 64'(k * 2),
            64'h7000 + 64'(k * 4), 5'(k), k[0]);
    end
    drive("idle", 0, 2'd0, 0, 64'h0, 64'h0, 64'h0, 5'd0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule